// File: doc/BRIEF.md
# Predicate Compare Writeback Unit

This unit turns compare outcomes into predicate-register updates. Each cycle it accepts up to `NLANE` compare operations (lanes). Every lane carries:

- a relation result bit;
- a qualifying predicate value;
- a deferred-exception flag covering the source operands;
- a 3-bit compare kind;
- two target predicate indices.

For each target, the unit decides whether the lane writes it and with what value. It then commits all lane writes to a file of `NPRED` one-bit predicates at the next rising clock edge.

The compare kinds follow five rules:

- **Normal:** the update is gated by the qualifying predicate.
- **Unconditional:** always writes both targets.
- **Parallel-AND, parallel-OR and OR-with-complement:** each writes only on one outcome.

With the parallel kinds, several compares aimed at the same predicates in one cycle merge into a single correct result. Entry 0 is a constant true predicate. Combinational read ports let the surrounding pipeline, or a bench, observe the file.

Top module: `pred_cmp_wb`

## Requirements
- R1: After synchronous reset every entry 1..NPRED-1 reads 0 and entry 0 reads 1.
- R2: Kind code 0 (normal): when qp=1, target one gets the relation and target two gets its inverse; when qp=0, nothing is written.
- R3: Kind code 1 (unconditional): both targets are written regardless of qp. Target one gets qp AND relation; target two gets qp AND NOT relation.
- R4: Kind code 2 (parallel AND): when qp=1 and the relation is 0, both targets become 0. Otherwise nothing is written, and this kind never sets a predicate.
- R5: Kind code 3 (parallel OR): when qp=1 and the relation is 1, both targets become 1. Otherwise nothing is written, and this kind never clears a predicate.
- R6: Kind code 4 (OR with complement): when qp=1 and the relation is 1, target one becomes 1 and target two becomes 0. Otherwise nothing is written.
- R7: A set deferred-exception flag makes the lane treat its relation as 0 for all kinds.
- R8: Index 0 always reads 1, and writes aimed at it are dropped.
- R9: When one lane names the same index for both targets, the target-one value is stored.
- R10: When lanes write the same index in one cycle, the lowest-numbered lane's value is stored. Several parallel-AND lanes on one pair leave it cleared if any of them clears it.
- R11: Kind codes 5, 6 and 7, and lanes with valid low, write nothing.
- R12: A write issued in a cycle is visible on the read ports right after the next rising edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | NLANE | Per-lane operation present |
| op_kind | input | NLANE x 3 | Per-lane compare kind code |
| op_qp | input | NLANE | Per-lane qualifying predicate value |
| op_rel | input | NLANE | Per-lane relation outcome |
| op_nat | input | NLANE | Per-lane deferred-exception flag on sources |
| op_t1 | input | NLANE x log2(NPRED) | Per-lane first target index |
| op_t2 | input | NLANE x log2(NPRED) | Per-lane second target index |
| rd_idx | input | NRD x log2(NPRED) | Read port indices |
| rd_val | output | NRD | Read port predicate values |

## Verification
The bench aims at the conditions a decoder tends to get wrong:

- **Unconditional kind with qp=0.** A design that skipped it would leave stale ones where zeros belong.
- **Parallel kinds on the opposite outcome.** A design that wrote anyway would corrupt the accumulated predicate.
- **Deferred-exception flag with a true relation.** Ignoring it would set predicates that should be cleared or left alone.
- **Index 0, identical targets, and two lanes colliding on one pair.** These expose a writable constant, a wrong target-one/target-two priority, or an AND merge where a later lane's no-op hides an earlier clear.

A behavioural model tracks the whole file against long random streams that mix all eight kind codes.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

    typedef enum logic [2:0] {
        K_NORM   = 3'd0,
        K_UNC    = 3'd1,
        K_PAND   = 3'd2,
        K_POR    = 3'd3,
        K_ORCM   = 3'd4
    } cmp_kind_e;

    // Per-lane write decision for the two targets
    typedef struct packed {
        logic we1;
        logic v1;
        logic we2;
        logic v2;
    } pwr_t;

    // r is the effective relation (already forced low on deferred exception)
    function automatic pwr_t cmp_write(logic [2:0] kind, logic qp, logic r);
        pwr_t w;
        w = '0;
        case (kind)
            K_NORM: begin
                w.we1 = qp;
                w.we2 = qp;
                w.v1  = r;
                w.v2  = ~r;
            end
            K_UNC: begin
                w.we1 = 1'b1;
                w.we2 = 1'b1;
                w.v1  = qp & r;
                w.v2  = qp & ~r;
            end
            K_PAND: begin
                w.we1 = qp & ~r;
                w.we2 = qp & ~r;
            end
            K_POR: begin
                w.we1 = qp & r;
                w.we2 = qp & r;
                w.v1  = 1'b1;
                w.v2  = 1'b1;
            end
            K_ORCM: begin
                w.we1 = qp & r;
                w.we2 = qp & r;
                w.v1  = 1'b1;
            end
            default: w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/pcw_lane_dec.sv
module pcw_lane_dec
    import pcw_pkg::*;
(
    input  logic       valid,
    input  logic [2:0] kind,
    input  logic       qp,
    input  logic       rel,
    input  logic       nat,
    output pwr_t       wr
);
    logic rel_eff;

    assign rel_eff = rel & ~nat;

    always_comb begin
        if (valid) wr = cmp_write(kind, qp, rel_eff);
        else       wr = '0;
    end
endmodule

// File: rtl/pcw_pfile.sv
module pcw_pfile
    import pcw_pkg::*;
#(
    parameter int NPRED = 64,
    parameter int NLANE = 2,
    parameter int NRD   = 2,
    localparam int IW   = $clog2(NPRED)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  pwr_t [NLANE-1:0]           wr,
    input  logic [NLANE-1:0][IW-1:0]   t1,
    input  logic [NLANE-1:0][IW-1:0]   t2,
    input  logic [NRD-1:0][IW-1:0]     rd_idx,
    output logic [NRD-1:0]             rd_val,
    output logic [NPRED-1:0]           state
);
    logic [NPRED-1:0] st;
    logic [NPRED-1:0] nxt;

    // Lowest lane applied last so it wins; inside a lane target one is applied last
    always_comb begin
        nxt = st;
        for (int l = NLANE - 1; l >= 0; l--) begin
            if (wr[l].we2) nxt[t2[l]] = wr[l].v2;
            if (wr[l].we1) nxt[t1[l]] = wr[l].v1;
        end
        nxt[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_val[r] = (rd_idx[r] == '0) ? 1'b1 : st[rd_idx[r]];
    end

    assign state = st;
endmodule

// File: rtl/pred_cmp_wb.sv
module pred_cmp_wb
    import pcw_pkg::*;
#(
    parameter int NPRED = 64,
    parameter int NLANE = 2,
    parameter int NRD   = 2,
    localparam int IW   = $clog2(NPRED)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NLANE-1:0]           op_valid,
    input  logic [NLANE-1:0][2:0]      op_kind,
    input  logic [NLANE-1:0]           op_qp,
    input  logic [NLANE-1:0]           op_rel,
    input  logic [NLANE-1:0]           op_nat,
    input  logic [NLANE-1:0][IW-1:0]   op_t1,
    input  logic [NLANE-1:0][IW-1:0]   op_t2,
    input  logic [NRD-1:0][IW-1:0]     rd_idx,
    output logic [NRD-1:0]             rd_val
);
    pwr_t [NLANE-1:0]   lane_wr;
    logic [NPRED-1:0]   pstate;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        pcw_lane_dec u_dec (
            .valid (op_valid[l]),
            .kind  (op_kind[l]),
            .qp    (op_qp[l]),
            .rel   (op_rel[l]),
            .nat   (op_nat[l]),
            .wr    (lane_wr[l])
        );
    end

    pcw_pfile #(.NPRED(NPRED), .NLANE(NLANE), .NRD(NRD)) u_pf (
        .clk    (clk),
        .rst    (rst),
        .wr     (lane_wr),
        .t1     (op_t1),
        .t2     (op_t2),
        .rd_idx (rd_idx),
        .rd_val (rd_val),
        .state  (pstate)
    );
endmodule

// File: rtl/pcw_chk.sv
module pcw_chk #(
    parameter int NPRED = 64,
    parameter int NLANE = 2,
    parameter int NRD   = 2,
    localparam int IW   = $clog2(NPRED)
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NLANE-1:0]           op_valid,
    input logic [NLANE-1:0][2:0]      op_kind,
    input logic [NLANE-1:0]           op_qp,
    input logic [NLANE-1:0]           op_rel,
    input logic [NLANE-1:0]           op_nat,
    input logic [NLANE-1:0][IW-1:0]   op_t1,
    input logic [NRD-1:0][IW-1:0]     rd_idx,
    input logic [NRD-1:0]             rd_val,
    input logic [NPRED-1:0]           pstate
);
    logic none_valid, all_and, all_or;

    always_comb begin
        none_valid = (op_valid == '0);
        all_and    = 1'b1;
        all_or     = 1'b1;
        for (int l = 0; l < NLANE; l++) begin
            if (op_valid[l] && op_kind[l] != 3'd2) all_and = 1'b0;
            if (op_valid[l] && op_kind[l] != 3'd3) all_or  = 1'b0;
        end
    end

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        none_valid |=> $stable(pstate));

    // R4
    and_never_sets_chk: assert property (@(posedge clk) disable iff (rst)
        all_and |=> ((pstate & ~$past(pstate)) == '0));

    // R5
    or_never_clears_chk: assert property (@(posedge clk) disable iff (rst)
        all_or |=> ((~pstate & $past(pstate)) == '0));

    // R3 R7
    unc_lane0_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid[0] && op_kind[0] == 3'd1 && op_t1[0] != '0)
        |=> pstate[$past(op_t1[0])] == $past(op_qp[0] & op_rel[0] & ~op_nat[0]));

    for (genvar k = 0; k < NRD; k++) begin : g_p0
        // R8
        zero_reads_true_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_idx[k] == '0) |-> rd_val[k]);
    end
endmodule

bind pred_cmp_wb pcw_chk #(.NPRED(NPRED), .NLANE(NLANE), .NRD(NRD)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .op_qp    (op_qp),
    .op_rel   (op_rel),
    .op_nat   (op_nat),
    .op_t1    (op_t1),
    .rd_idx   (rd_idx),
    .rd_val   (rd_val),
    .pstate   (pstate)
);

// File: tb/tb_pred_cmp_wb.sv
`timescale 1ns/1ps
module tb_pred_cmp_wb;
    localparam int NL = 2;
    localparam int NR = 2;
    localparam int IW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NL-1:0]          op_valid = '0;
    logic [NL-1:0][2:0]     op_kind  = '0;
    logic [NL-1:0]          op_qp    = '0;
    logic [NL-1:0]          op_rel   = '0;
    logic [NL-1:0]          op_nat   = '0;
    logic [NL-1:0][IW-1:0]  op_t1    = '0;
    logic [NL-1:0][IW-1:0]  op_t2    = '0;
    logic [NR-1:0][IW-1:0]  rd_idx   = '0;
    logic [NR-1:0]          rd_val;

    // staged operation per lane
    bit       s_valid [NL];
    bit [2:0] s_kind  [NL];
    bit       s_qp    [NL];
    bit       s_rel   [NL];
    bit       s_nat   [NL];
    int       s_t1    [NL];
    int       s_t2    [NL];

    bit mref [64];
    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pred_cmp_wb dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_qp(op_qp), .op_rel(op_rel), .op_nat(op_nat),
        .op_t1(op_t1), .op_t2(op_t2), .rd_idx(rd_idx), .rd_val(rd_val)
    );

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    function automatic bit exp_rd(int i);
        return (i == 0) ? 1'b1 : mref[i];
    endfunction

    // Behavioural model of the compare rules: lanes applied from highest to
    // lowest priority last, target two before target one.
    task automatic model_apply();
        for (int l = NL - 1; l >= 0; l--) begin
            bit r, w1, w2, v1, v2;
            if (!s_valid[l]) continue;
            r = s_rel[l] && !s_nat[l];
            w1 = 0; w2 = 0; v1 = 0; v2 = 0;
            case (s_kind[l])
                3'd0: begin w1 = s_qp[l]; w2 = s_qp[l]; v1 = r; v2 = !r; end
                3'd1: begin w1 = 1; w2 = 1; v1 = s_qp[l] && r; v2 = s_qp[l] && !r; end
                3'd2: if (s_qp[l] && !r) begin w1 = 1; w2 = 1; v1 = 0; v2 = 0; end
                3'd3: if (s_qp[l] && r)  begin w1 = 1; w2 = 1; v1 = 1; v2 = 1; end
                3'd4: if (s_qp[l] && r)  begin w1 = 1; w2 = 1; v1 = 1; v2 = 0; end
                default: ;
            endcase
            if (w2 && s_t2[l] != 0) mref[s_t2[l]] = v2;
            if (w1 && s_t1[l] != 0) mref[s_t1[l]] = v1;
        end
    endtask

    task automatic clear_stage();
        for (int l = 0; l < NL; l++) begin
            s_valid[l] = 0; s_kind[l] = 0; s_qp[l] = 0; s_rel[l] = 0;
            s_nat[l] = 0; s_t1[l] = 0; s_t2[l] = 0;
        end
    endtask

    task automatic stage(int l, int kind, bit qp, bit rel, bit nat, int t1, int t2);
        s_valid[l] = 1; s_kind[l] = 3'(kind); s_qp[l] = qp; s_rel[l] = rel;
        s_nat[l] = nat; s_t1[l] = t1; s_t2[l] = t2;
    endtask

    // drive staged ops at a falling edge, commit at the rising edge, then idle
    task automatic run_cycle();
        @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            op_valid[l] = s_valid[l];
            op_kind[l]  = s_kind[l];
            op_qp[l]    = s_qp[l];
            op_rel[l]   = s_rel[l];
            op_nat[l]   = s_nat[l];
            op_t1[l]    = IW'(s_t1[l]);
            op_t2[l]    = IW'(s_t2[l]);
        end
        @(posedge clk);
        model_apply();
        #0.5;
        op_valid = '0;
        clear_stage();
        #0.5;
    endtask

    task automatic check_pair(string tag, int a, int b);
        rd_idx[0] = IW'(a);
        rd_idx[1] = IW'(b);
        #0.05;
        checks++;
        if (rd_val[0] !== exp_rd(a)) begin
            failures++;
            $display("FAIL %s p%0d actual=%b expected=%b", tag, a, rd_val[0], exp_rd(a));
        end
        checks++;
        if (rd_val[1] !== exp_rd(b)) begin
            failures++;
            $display("FAIL %s p%0d actual=%b expected=%b", tag, b, rd_val[1], exp_rd(b));
        end
    endtask

    task automatic scan(string tag);
        for (int i = 0; i < 64; i += 2) check_pair(tag, i, i + 1);
    endtask

    // set a pair to 1 using a parallel OR on lane 0
    task automatic preset_ones(int a, int b);
        stage(0, 3, 1, 1, 0, a, b);
        run_cycle();
    endtask

    initial begin
        foreach (mref[i]) mref[i] = 0;
        clear_stage();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #0.5;
        scan("R1 reset");

        // R2 normal kind
        stage(0, 0, 1, 1, 0, 5, 6); run_cycle(); check_pair("R2 qp1 rel1", 5, 6);
        stage(0, 0, 1, 0, 0, 7, 8); run_cycle(); check_pair("R2 qp1 rel0", 7, 8);
        stage(0, 0, 0, 0, 0, 5, 6); run_cycle(); check_pair("R2 qp0 no write", 5, 6);

        // R3 unconditional kind
        preset_ones(10, 11);
        stage(0, 1, 0, 1, 0, 10, 11); run_cycle(); check_pair("R3 qp0 clears both", 10, 11);
        stage(0, 1, 1, 0, 0, 10, 11); run_cycle(); check_pair("R3 qp1 rel0", 10, 11);
        stage(0, 1, 1, 1, 0, 12, 13); run_cycle(); check_pair("R3 qp1 rel1", 12, 13);

        // R4 parallel AND
        preset_ones(14, 15);
        stage(0, 2, 1, 1, 0, 14, 15); run_cycle(); check_pair("R4 rel1 no write", 14, 15);
        stage(0, 2, 0, 0, 0, 14, 15); run_cycle(); check_pair("R4 qp0 no write", 14, 15);
        stage(0, 2, 1, 0, 0, 14, 15); run_cycle(); check_pair("R4 rel0 clears", 14, 15);

        // R5 parallel OR
        stage(0, 3, 1, 0, 0, 16, 17); run_cycle(); check_pair("R5 rel0 no write", 16, 17);
        stage(0, 3, 0, 1, 0, 16, 17); run_cycle(); check_pair("R5 qp0 no write", 16, 17);
        stage(0, 3, 1, 1, 0, 16, 17); run_cycle(); check_pair("R5 rel1 sets", 16, 17);

        // R6 OR with complement
        preset_ones(18, 19);
        stage(0, 4, 1, 0, 0, 18, 19); run_cycle(); check_pair("R6 rel0 no write", 18, 19);
        stage(0, 4, 1, 1, 0, 20, 18); run_cycle(); check_pair("R6 rel1 set/clear", 20, 18);

        // R7 deferred exception forces relation false
        stage(0, 0, 1, 1, 1, 21, 22); run_cycle(); check_pair("R7 normal nat", 21, 22);
        stage(0, 3, 1, 1, 1, 23, 24); run_cycle(); check_pair("R7 or nat", 23, 24);
        preset_ones(25, 26);
        stage(0, 2, 1, 1, 1, 25, 26); run_cycle(); check_pair("R7 and nat", 25, 26);

        // R8 index zero
        stage(0, 0, 1, 0, 0, 0, 27); run_cycle(); check_pair("R8 write p0", 0, 27);
        stage(1, 1, 0, 0, 0, 0, 0);  run_cycle(); check_pair("R8 unc p0", 0, 0);

        // R9 same target twice
        stage(0, 0, 1, 1, 0, 28, 28); run_cycle(); check_pair("R9 normal", 28, 28);
        stage(0, 4, 1, 1, 0, 29, 29); run_cycle(); check_pair("R9 orcm", 29, 29);

        // R10 lane merge
        preset_ones(30, 31);
        stage(0, 2, 1, 1, 0, 30, 31);
        stage(1, 2, 1, 0, 0, 30, 31);
        run_cycle(); check_pair("R10 and merge lane1 clears", 30, 31);
        preset_ones(32, 33);
        stage(0, 2, 1, 0, 0, 32, 33);
        stage(1, 2, 1, 1, 0, 32, 33);
        run_cycle(); check_pair("R10 and merge lane0 clears", 32, 33);
        stage(0, 0, 1, 1, 0, 34, 35);
        stage(1, 0, 1, 0, 0, 34, 35);
        run_cycle(); check_pair("R10 lane0 priority", 34, 35);

        // R11 reserved codes and idle lanes
        preset_ones(36, 37);
        for (int k = 5; k < 8; k++) begin
            stage(0, k, 1, 0, 0, 36, 37);
            stage(1, k, 1, 1, 0, 38, 39);
            run_cycle();
            check_pair("R11 reserved code", 36, 37);
            check_pair("R11 reserved code", 38, 39);
        end
        stage(0, 1, 1, 1, 0, 36, 37);
        s_valid[0] = 0;
        run_cycle(); check_pair("R11 valid low", 36, 37);
        scan("R11 full file");

        // R12 random streams, checked right after every edge
        for (int n = 0; n < 4000; n++) begin
            for (int l = 0; l < NL; l++) begin
                if ($urandom_range(0, 7) != 0)
                    stage(l, int'($urandom_range(0, 7)), 1'($urandom), 1'($urandom),
                          ($urandom_range(0, 5) == 0),
                          int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));
            end
            begin
                int a0, b0, a1, b1;
                a0 = s_t1[0]; b0 = s_t2[0]; a1 = s_t1[1]; b1 = s_t2[1];
                run_cycle();
                check_pair("R12 random", a0, b0);
                check_pair("R12 random", a1, b1);
            end
            if (n % 500 == 499) scan("R12 random scan");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule